// File: doc/BRIEF.md
# GPIO Pin Data and Direction Register Bank

This block is the data path of a 16-pin general-purpose I/O port, reached over a plain memory-mapped bus (address, write enable, write data, read enable, read data). It holds one direction bit per pin and one output bit per pin. Each pin drives a tristate pad through an output-enable and an output-value signal, and the pad level comes back through a two-flop synchronizer before software can read it.

The output register can be written whole, or single bits can be raised or lowered without a read-modify-write through a write-one-to-set address and a write-one-to-clear address. Reads return data one clock after the read request.

Top module: `gpio_regbank`

## Requirements
- R1: After reset the direction register is all ones, so every pin is an input. The output register is 0, every `pad_oe_o` bit is 0 and `rdata_o` is 0.
- R2: A write to offset 0x00 loads the direction register. Pin n drives its pad (`pad_oe_o[n]`=1) exactly when direction bit n is 0. A 1 makes the pin an input.
- R3: A write to offset 0x08 sets each output bit whose write-data bit is 1 and leaves the other output bits unchanged. Writing 0x0100 raises pin 8 only.
- R4: A write to offset 0x0C clears each output bit whose write-data bit is 1 and leaves the other output bits unchanged.
- R5: A write to offset 0x04 replaces all output bits at once with the write data.
- R6: A read request is answered on `rdata_o` after the clock edge that samples `re_i`, and `rdata_o` is 0 after an edge where `re_i` is low. Offset 0x00 returns the direction register. Offsets 0x04, 0x08 and 0x0C all return the output register, not the pad level.
- R7: Offset 0x10 returns the pad inputs through two synchronizing flops. After a pad change, reads sampled at the first and second following edges return the old level, and a read at the third edge returns the new level.
- R8: Reads of offsets other than 0x00, 0x04, 0x08, 0x0C and 0x10 return 0. Writes to 0x10 or to an unmapped offset change neither the direction register nor the output register.
- R9: On a pin configured as input, writes to the output, set and clear offsets still update the output bit but do not drive the pad. The stored value appears on the pad once the pin becomes an output.
- R10: When a read and a write hit the block in the same cycle, the read returns the register contents from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Peripheral clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | AW (5) | Byte offset of the accessed register |
| we_i | input | 1 | Write strobe |
| wdata_i | input | NPIN (16) | Write data, one bit per pin |
| re_i | input | 1 | Read strobe |
| rdata_o | output | DW (32) | Registered read data, zero-extended |
| pad_in_i | input | NPIN (16) | Asynchronous pad levels |
| pad_oe_o | output | NPIN (16) | Pad output enable, 1 drives |
| pad_out_o | output | NPIN (16) | Pad output value |

## Verification
A read and a write can be accepted on the same clock edge, and they can address the same register. The bench raises `we_i` and `re_i` together on the set offset and on the direct output offset. It expects the read to return the pre-write contents and a following read to show the updated value. The bench also reads the input offset on consecutive edges after a pad change, to pin down the exact two-flop latency.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam logic [15:0] OFF_DIR = 16'h0000;
  localparam logic [15:0] OFF_OUT = 16'h0004;
  localparam logic [15:0] OFF_SET = 16'h0008;
  localparam logic [15:0] OFF_CLR = 16'h000C;
  localparam logic [15:0] OFF_IN  = 16'h0010;

  typedef enum logic [2:0] {
    SEL_DIR, SEL_OUT, SEL_SET, SEL_CLR, SEL_IN, SEL_NONE
  } reg_sel_e;

  function automatic reg_sel_e decode(input logic [15:0] a);
    case (a)
      OFF_DIR: decode = SEL_DIR;
      OFF_OUT: decode = SEL_OUT;
      OFF_SET: decode = SEL_SET;
      OFF_CLR: decode = SEL_CLR;
      OFF_IN:  decode = SEL_IN;
      default: decode = SEL_NONE;
    endcase
  endfunction
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int NPIN = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NPIN-1:0] d_i,
  output logic [NPIN-1:0] q_o
);
  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    logic s1_q, s2_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q <= 1'b0;
        s2_q <= 1'b0;
      end else begin
        s1_q <= d_i[i];
        s2_q <= s1_q;
      end
    end
    assign q_o[i] = s2_q;
  end
endmodule

// File: rtl/gpio_ctl_regs.sv
module gpio_ctl_regs
  import gpio_pkg::*;
#(
  parameter int NPIN = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  reg_sel_e        sel_i,
  input  logic [NPIN-1:0] wdata_i,
  output logic [NPIN-1:0] dir_q_o,
  output logic [NPIN-1:0] out_q_o
);
  logic [NPIN-1:0] dir_q, out_q, out_d;

  always_comb begin
    out_d = out_q;
    if (we_i) begin
      case (sel_i)
        SEL_OUT: out_d = wdata_i;
        SEL_SET: out_d = out_q | wdata_i;
        SEL_CLR: out_d = out_q & ~wdata_i;
        default: out_d = out_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q <= '1;
      out_q <= '0;
    end else begin
      if (we_i && sel_i == SEL_DIR) dir_q <= wdata_i;
      out_q <= out_d;
    end
  end

  assign dir_q_o = dir_q;
  assign out_q_o = out_q;

  a_r3_set_keeps_others: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && sel_i == SEL_SET) |=> ((out_q & ~$past(wdata_i)) == ($past(out_q) & ~$past(wdata_i))));
  a_r4_clr_keeps_others: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && sel_i == SEL_CLR) |=> ((out_q & ~$past(wdata_i)) == ($past(out_q) & ~$past(wdata_i))));
  a_r8_idle_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!we_i || sel_i == SEL_IN || sel_i == SEL_NONE) |=> ($stable(out_q) && $stable(dir_q)));
endmodule

// File: rtl/gpio_rd_mux.sv
module gpio_rd_mux
  import gpio_pkg::*;
#(
  parameter int NPIN = 16,
  parameter int DW   = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            re_i,
  input  reg_sel_e        sel_i,
  input  logic [NPIN-1:0] dir_i,
  input  logic [NPIN-1:0] out_i,
  input  logic [NPIN-1:0] in_i,
  output logic [DW-1:0]   rdata_o
);
  logic [NPIN-1:0] pick;

  always_comb begin
    case (sel_i)
      SEL_DIR:                   pick = dir_i;
      SEL_OUT, SEL_SET, SEL_CLR: pick = out_i;
      SEL_IN:                    pick = in_i;
      default:                   pick = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (re_i) rdata_o <= DW'(pick);
    else           rdata_o <= '0;
  end

  a_r8_unmapped_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && sel_i == SEL_NONE) |=> (rdata_o == '0));
  a_r6_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !re_i |=> (rdata_o == '0));
endmodule

// File: rtl/gpio_regbank.sv
module gpio_regbank
  import gpio_pkg::*;
#(
  parameter int NPIN = 16,
  parameter int DW   = 32,
  parameter int AW   = 5
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [AW-1:0]   addr_i,
  input  logic            we_i,
  input  logic [NPIN-1:0] wdata_i,
  input  logic            re_i,
  output logic [DW-1:0]   rdata_o,
  input  logic [NPIN-1:0] pad_in_i,
  output logic [NPIN-1:0] pad_oe_o,
  output logic [NPIN-1:0] pad_out_o
);
  logic [15:0]     addr_ext;
  reg_sel_e        sel;
  logic [NPIN-1:0] dir_q, out_q, in_sync;

  assign addr_ext = 16'(addr_i);
  assign sel      = decode(addr_ext);

  gpio_ctl_regs #(.NPIN(NPIN)) u_regs (
    .clk_i, .rst_ni, .we_i, .sel_i(sel), .wdata_i,
    .dir_q_o(dir_q), .out_q_o(out_q)
  );

  gpio_in_sync #(.NPIN(NPIN)) u_sync (
    .clk_i, .rst_ni, .d_i(pad_in_i), .q_o(in_sync)
  );

  gpio_rd_mux #(.NPIN(NPIN), .DW(DW)) u_rd (
    .clk_i, .rst_ni, .re_i, .sel_i(sel),
    .dir_i(dir_q), .out_i(out_q), .in_i(in_sync), .rdata_o
  );

  // direction bit 1 = input, so drive only where it is 0
  assign pad_oe_o  = ~dir_q;
  assign pad_out_o = out_q;

  a_r2_oe_after_dir_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && sel == SEL_DIR) |=> (pad_oe_o == ~$past(wdata_i)));
  a_r5_direct_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && sel == SEL_OUT) |=> (pad_out_o == $past(wdata_i)));
  a_r9_oe_stable_on_data_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && sel != SEL_DIR) |=> $stable(pad_oe_o));
endmodule

// File: tb/sim_gpio_regbank.sv
module sim_gpio_regbank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  addr = '0;
  logic        we = 1'b0, re = 1'b0;
  logic [15:0] wdata = '0;
  logic [31:0] rdata;
  logic [15:0] pad_in = '0;
  logic [15:0] pad_oe, pad_out;
  int checks = 0, fails = 0;
  logic [31:0] r;

  always #5 clk = ~clk;

  gpio_regbank u0 (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we), .wdata_i(wdata),
    .re_i(re), .rdata_o(rdata), .pad_in_i(pad_in), .pad_oe_o(pad_oe), .pad_out_o(pad_out)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // tasks start and end just after a falling edge
  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    addr = a; wdata = d; we = 1'b1;
    @(posedge clk); @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] q);
    addr = a; re = 1'b1;
    @(posedge clk); #1 q = rdata;
    @(negedge clk);
    re = 1'b0;
  endtask

  task automatic wr_rd(input logic [4:0] a, input logic [15:0] d, output logic [31:0] q);
    addr = a; wdata = d; we = 1'b1; re = 1'b1;
    @(posedge clk); #1 q = rdata;
    @(negedge clk);
    we = 1'b0; re = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 rdata", rdata, 0);
    chk("R1 oe", {16'h0, pad_oe}, 0);
    chk("R1 out", {16'h0, pad_out}, 0);
    rd(5'h00, r); chk("R1 dir", r, 32'h0000FFFF);
  endtask

  task automatic t_dir;
    wr(5'h00, 16'h00F0);
    chk("R2 oe", {16'h0, pad_oe}, 32'h0000FF0F);
    rd(5'h00, r); chk("R2 dir read", r, 32'h000000F0);
    @(negedge clk); chk("R6 idle rdata", rdata, 0);
  endtask

  task automatic t_out_ops;
    wr(5'h04, 16'hA5C3);
    chk("R5 direct", {16'h0, pad_out}, 32'h0000A5C3);
    wr(5'h04, 16'h0000);
    wr(5'h08, 16'h0100);
    chk("R3 set gp8", {16'h0, pad_out}, 32'h00000100);
    wr(5'h08, 16'h0003);
    chk("R3 set keeps", {16'h0, pad_out}, 32'h00000103);
    wr(5'h0C, 16'h0101);
    chk("R4 clear", {16'h0, pad_out}, 32'h00000002);
    wr(5'h0C, 16'h0000);
    chk("R4 zero no effect", {16'h0, pad_out}, 32'h00000002);
  endtask

  task automatic t_readback;
    pad_in = 16'hFFFF;
    wr(5'h04, 16'h1234);
    rd(5'h04, r); chk("R6 out read", r, 32'h00001234);
    rd(5'h08, r); chk("R6 set read", r, 32'h00001234);
    rd(5'h0C, r); chk("R6 clr read", r, 32'h00001234);
  endtask

  task automatic t_sync;
    pad_in = 16'h0000;
    repeat (3) @(negedge clk);
    pad_in = 16'h5A5A;
    rd(5'h10, r);
    rd(5'h10, r); chk("R7 edge2 old", r, 0);
    rd(5'h10, r); chk("R7 edge3 new", r, 32'h00005A5A);
  endtask

  task automatic t_unmapped;
    wr(5'h04, 16'h00FF);
    rd(5'h14, r); chk("R8 unmapped read", r, 0);
    rd(5'h01, r); chk("R8 misaligned read", r, 0);
    wr(5'h10, 16'hFFFF);
    wr(5'h1C, 16'hFFFF);
    chk("R8 out untouched", {16'h0, pad_out}, 32'h000000FF);
    rd(5'h00, r); chk("R8 dir untouched", r, 32'h000000F0);
  endtask

  task automatic t_input_pin;
    wr(5'h00, 16'hFFFF);
    wr(5'h04, 16'h0000);
    wr(5'h08, 16'h8000);
    chk("R9 oe low", {16'h0, pad_oe}, 0);
    rd(5'h04, r); chk("R9 reg updated", r, 32'h00008000);
    wr(5'h00, 16'h7FFF);
    chk("R9 driven now", {16'h0, pad_oe & pad_out}, 32'h00008000);
  endtask

  task automatic t_collide;
    wr(5'h04, 16'h00F0);
    wr_rd(5'h08, 16'h000F, r); chk("R10 old on set", r, 32'h000000F0);
    rd(5'h08, r); chk("R10 new after set", r, 32'h000000FF);
    wr_rd(5'h04, 16'h1111, r); chk("R10 old on direct", r, 32'h000000FF);
    rd(5'h04, r); chk("R10 new after direct", r, 32'h00001111);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_dir;
    t_out_ops;
    t_readback;
    t_sync;
    t_unmapped;
    t_input_pin;
    t_collide;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule